// File: doc/BRIEF.md
# Period-Match Interval Timer with Prescaler and Postscaler

This block is an 8-bit interval timer. A prescaler divides the clock into ticks. On each tick the count register steps up by one. When the count has reached the programmed period value, the next tick returns it to zero. One timer cycle therefore lasts period+1 ticks.

Each return to zero raises a one-clock event strobe, which a neighbouring PWM generator can use as its cycle boundary. The same event advances a 4-bit postscaler. When the postscaler completes its programmed ratio, a sticky interrupt flag is set.

Software controls the block through a small register port. There is one write channel and one combinational read channel. They give access to the count, the period, a control byte (enable, prescale code, postscale ratio) and the flag.

Top module: `tpt_top`

## Requirements
- R1: With the count at or below the period, each tick adds one to the count. The tick that finds the count equal to the period loads zero instead, so one cycle lasts period+1 ticks.
- R2: The prescale code sits in control bits [2:1]. Code 00 gives one tick per enabled clock, 01 one tick per 4 clocks, 10 one per 16 and 11 one per 64.
- R3: A count written above the period keeps rising to 255 and then wraps to 0. That wrap raises no match strobe and does not advance the postscaler.
- R4: `match_o` is high for exactly the one clock in which the count has just been returned to zero by a period match.
- R5: Control bits [6:3] hold n. The interrupt flag is set on every (n+1)-th match, so n=0 gives 1:1 and n=15 gives 1:16.
- R6: A write to address 0 (count) or address 2 (control) clears the prescaler and postscaler counters and suppresses any tick in that clock. An address 0 write loads the count with the written byte.
- R7: The interrupt flag, seen on `irq_o`, stays set until software writes address 3 with bit 0 equal to 1. If a set and a clear fall in the same clock, the set wins.
- R8: Control bit 0 is the enable. While it is 0, the count and the prescaler hold their values and no match occurs.
- R9: After a synchronous reset, the count is 0, the period is 0xFF, the control byte is 0 and the flag is clear.
- R10: `rd_data` shows the count at address 0, the period at address 1, the control byte (bit 7 reads 0) at address 2 and the flag in bit 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 period, 2 control, 3 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Combinational read data |
| match_o | output | 1 | One-clock period-match strobe for a PWM generator |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench aims at period 0 with prescale 1:1, where a match falls on every clock. A design that kept the strobe one cycle late or held the count at the period for an extra tick would drift from the model there at once.

It loads a count above the period. A design that compared with "greater or equal" would strobe early, and one that missed the wrap would not return to zero.

It repeats flag clears while matches land every clock, which catches a design that lets the clear win over a set in the same clock. Writes to the control register in the middle of a prescale interval expose a prescaler or postscaler that is not cleared, because the next tick then arrives early.

// File: rtl/tpt_pkg.sv
// Package: shared widths and register addresses for the period-match timer.
// Assumes a 2-bit register address space with four byte-wide registers.
package tpt_pkg;
    localparam int CNT_W     = 8;
    localparam int PRE_SEL_W = 2;
    localparam int POST_W    = 4;
    localparam int ADDR_W    = 2;
    // Each prescale code step multiplies the ratio by four (two bits).
    localparam int PRE_W     = 2 * ((1 << PRE_SEL_W) - 1);

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT  = 2'd0,
        A_PERIOD = 2'd1,
        A_CTRL   = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tpt_prescaler.sv
// Module: clock-to-tick divider. Emits a one-clock tick once every 4^sel
// enabled clocks. Assumes sel only changes together with clr.
module tpt_prescaler #(
    parameter int SEL_W = 2,
    parameter int W     = 2 * ((1 << SEL_W) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;

    // Last count value before the tick for the selected ratio.
    always_comb limit = W'((32'd1 << (32'(sel) * 2)) - 32'd1);

    assign tick = en && !clr && (cnt_q == limit);

    // Divider counter: cleared on reset or clear, wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (en)        cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= limit);  // R2
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt_q));  // R8
endmodule

// File: rtl/tpt_counter.sv
// Module: the timer count register and period compare. It loads on a
// software write and returns to zero on the tick after reaching the period.
// Assumes tick is already suppressed during a load.
module tpt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         match_now,
    output logic         match_q
);
    assign match_now = tick && (count == period);

    // Count register: load beats tick; match returns to zero, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (load)       count <= load_val;
        else if (match_now)  count <= '0;
        else if (tick)       count <= count + 1'b1;
    end

    // Registered strobe aligned with the count returning to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now && !load;
    end

    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> count == '0);  // R4
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count == period) |=> count == '0);  // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != period) |=> count == $past(count) + 1'b1);  // R3
endmodule

// File: rtl/tpt_postscaler.sv
// Module: counts match events and fires on every (ratio+1)-th one.
// Assumes ratio only changes together with clr.
module tpt_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] ratio,
    output logic         fire
);
    logic [W-1:0] cnt_q;

    assign fire = evt && !clr && (cnt_q == ratio);

    // Event counter: cleared on reset or clear, wraps when it fires.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (evt)       cnt_q <= fire ? '0 : cnt_q + 1'b1;
    end

    AST_POST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= ratio);  // R5
endmodule

// File: rtl/tpt_top.sv
// Module: period-match interval timer with register port. Holds the
// period, control byte and sticky flag, and wires the prescaler, counter
// and postscaler. Assumes one register write per clock at most.
module tpt_top
    import tpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              match_o,
    output logic              irq_o
);
    localparam int CTRL_W = 1 + PRE_SEL_W + POST_W;

    logic [CNT_W-1:0]     period_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic                 flag_q;
    logic                 en;
    logic [PRE_SEL_W-1:0] pre_sel;
    logic [POST_W-1:0]    post_ratio;
    logic                 wr_count, wr_ctrl, wr_period, clr_flag, scalers_clr;
    logic                 tick, match_now, fire;
    logic [CNT_W-1:0]     count;

    assign en          = ctrl_q[0];
    assign pre_sel     = ctrl_q[PRE_SEL_W:1];
    assign post_ratio  = ctrl_q[CTRL_W-1:PRE_SEL_W+1];
    assign wr_count    = wr_en && (wr_addr == A_COUNT);
    assign wr_period   = wr_en && (wr_addr == A_PERIOD);
    assign wr_ctrl     = wr_en && (wr_addr == A_CTRL);
    assign clr_flag    = wr_en && (wr_addr == A_STATUS) && wr_data[0];
    assign scalers_clr = wr_count || wr_ctrl;

    // Period and control registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (wr_period) period_q <= wr_data;
            if (wr_ctrl)   ctrl_q   <= wr_data[CTRL_W-1:0];
        end
    end

    // Sticky interrupt flag: a set in the same clock beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (clr_flag) flag_q <= 1'b0;
    end

    tpt_prescaler #(.SEL_W(PRE_SEL_W), .W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(scalers_clr),
        .sel(pre_sel), .tick(tick)
    );

    tpt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_count),
        .load_val(wr_data), .period(period_q), .count(count),
        .match_now(match_now), .match_q(match_o)
    );

    tpt_postscaler #(.W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .clr(scalers_clr), .evt(match_now),
        .ratio(post_ratio), .fire(fire)
    );

    // Read multiplexer for the four registers.
    always_comb begin
        unique case (rd_addr)
            A_COUNT:  rd_data = count;
            A_PERIOD: rd_data = period_q;
            A_CTRL:   rd_data = CNT_W'(ctrl_q);
            default:  rd_data = CNT_W'(flag_q);
        endcase
    end

    assign irq_o = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_flag) |=> irq_o);  // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_o);  // R7
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_count) |=> ($stable(count) && !match_o));  // R8
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count == $past(wr_data));  // R6
endmodule

// File: tb/tpt_top_tb.sv
module tpt_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       match_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    tpt_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .match_o(match_o), .irq_o(irq_o)
    );

    // Behavioural reference model, advanced on every rising edge.
    int m_cnt, m_per, m_en, m_ps, m_post, m_pre, m_pc, m_flag, m_match;
    always @(posedge clk) begin
        int ratio;
        bit tk, setf;
        if (!rst_n) begin
            m_cnt = 0; m_per = 255; m_en = 0; m_ps = 0; m_post = 0;
            m_pre = 0; m_pc = 0; m_flag = 0; m_match = 0;
        end else begin
            ratio = 1 << (2 * m_ps);
            m_match = 0; setf = 0;
            if (wr_en && wr_addr == 0) begin          // R6 count write
                m_cnt = wr_data; m_pre = 0; m_pc = 0;
            end else if (wr_en && wr_addr == 2) begin // R6 control write
                m_pre = 0; m_pc = 0;
                m_en = wr_data[0]; m_ps = wr_data[2:1]; m_post = wr_data[6:3];
            end else if (m_en != 0) begin
                tk = (m_pre == ratio - 1);
                m_pre = tk ? 0 : m_pre + 1;
                if (tk) begin
                    if (m_cnt == m_per) begin
                        m_cnt = 0; m_match = 1;
                        if (m_pc == m_post) begin m_pc = 0; setf = 1; end
                        else m_pc = m_pc + 1;
                    end else m_cnt = (m_cnt + 1) % 256;
                end
            end
            if (wr_en && wr_addr == 1) m_per = wr_data;
            if (wr_en && wr_addr == 3 && wr_data[0]) m_flag = 0;
            if (setf) m_flag = 1;
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_cnt;
            1: return m_per;
            2: return (m_post << 3) | (m_ps << 1) | m_en;
            default: return m_flag;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model, then rotate the read address.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk("R4 match_o", int'(match_o), m_match);
        chk("R7 irq_o", int'(irq_o), m_flag);
        chk(rd_addr == 0 ? "R1 count" : "R10 readback", int'(rd_data), exp_rd(int'(rd_addr)));
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset values read through the port
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk("R9 reset", int'(rd_data), a == 1 ? 255 : 0);
        end
        chk("R9 reset irq", int'(irq_o), 0);
        // R8 disabled: nothing moves
        run(20);
        // R1 R4 period 3, prescale 1:1, postscale 1:1 (ctrl = {post,ps,en})
        wr(1, 3); wr(2, 8'h01); run(40);
        // R2 prescale 1:4 and 1:16
        wr(1, 2); wr(2, 8'h03); run(80);
        wr(2, 8'h05); run(200);
        // R2 prescale 1:64, period 1
        wr(1, 1); wr(2, 8'h07); run(400);
        // R5 postscale 1:3, clear flag midway
        wr(3, 1); wr(1, 2); wr(2, 8'h11); run(60);
        wr(3, 1); run(30);
        // R5 postscale 1:16
        wr(3, 1); wr(1, 0); wr(2, 8'h79); run(100);
        // R7 clears collide with sets at period 0, 1:1, 1:1
        wr(2, 8'h01);
        for (int i = 0; i < 10; i++) begin wr(3, 1); cyc(); end
        wr(3, 8'hFE); run(4);  // bit0 = 0: no clear
        // R3 count above period wraps at 255
        wr(3, 1); wr(1, 5); wr(0, 200); run(80);
        // R6 control write mid-interval restarts the prescaler
        wr(2, 8'h03); run(2); wr(2, 8'h03); run(10); wr(0, 1); run(10);
        // R8 disable mid-count, hold, re-enable
        wr(2, 8'h00); run(30); wr(2, 8'h01); run(20);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule